// File: doc/BRIEF.md
# SPI Flash Hardware Sequencer

This block runs complete serial-flash operations on a single SPI flash device without software ever shifting an opcode. Software loads a 24-bit flash address into one register and, for writes, fills a byte buffer through the register bus. It then writes the combined control/status word with the go bit set. The block then issues every frame on its own: write-enable, opcode, address, data and the busy polling that follows program and erase.

When the operation ends, a done flag rises. An error flag rises instead if the request was malformed or the device stayed busy too long. Both flags are cleared by writing ones. Read data lands in the same buffer, and software drains it byte-wise or word-wise. The serial side runs in mode 0, MSB first. Its clock is the system clock divided by a parameter.

Top module: `spi_hwseq`

## Requirements
- R1: After reset the control word (byte offset 0x00) reads 0, spi_cs_n is high and spi_sclk is low.
- R2: The flash-address register sits at offset 0x04 and reads back its low 24 bits. The buffer occupies offsets 0x40-0x7F, with buffer byte 4k+i in bits 8i+7:8i of word k. Bus address bits 1:0 are ignored, and bus_be selects the buffer bytes written. Read data appears on bus_rdata the cycle after bus_rd.
- R3: A control write with bit 8 (go) set starts an operation. The operation type comes from bits 11:9 and the byte count minus one from bits 23:16 of that same write, and both read back in those fields.
- R4: Type 0 (read) sends one frame: 0x03, three address bytes MSB first, then count bytes received into the buffer from index 0.
- R5: Type 1 (program) sends a one-byte 0x06 frame, then a frame of 0x02, the address and count bytes taken from buffer index 0.
- R6: Type 2 sends 0x20 and type 3 sends 0xD8, each as a four-byte frame (opcode plus address) after a 0x06 frame.
- R7: Type 4 sends 0x05 and stores count returned bytes into the buffer from index 0.
- R8: After program or erase the block repeats two-byte 0x05 frames until bit 0 of the returned byte is 0. Only then does it set done (control bit 0).
- R9: If POLL_MAX poll frames all return bit 0 set, the error flag (control bit 1) is set and done stays clear.
- R10: A go with count above the buffer size on types 0, 1 or 4, a program crossing a 256-byte page, or a type of 5-7 sets the error flag and never drives spi_cs_n low.
- R11: Writing 1 to control bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged.
- R12: Control bit 2 reads 1 while an operation runs, and a go written during that time is ignored.
- R13: spi_sclk is low whenever spi_cs_n is high, and frames are separated by spi_cs_n rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables for buffer writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The poll-timeout path is the hardest case to reach from the ports. It requires a device that reports busy on every status frame after an erase, and a real device never does that. The bench's behavioural flash model has a stuck-busy switch for this case, and the bench builds the block with a small POLL_MAX so that the full retry count is reached in a few frames. The ignored second go is the other awkward case. It is issued during a 64-byte read, which keeps the block busy long enough, and the model's frame log then shows that no write-enable frame followed.

// File: rtl/spi_hwseq_pkg.sv
package spi_hwseq_pkg;
  typedef enum logic [2:0] {
    CY_RD   = 3'd0,
    CY_PROG = 3'd1,
    CY_ER_S = 3'd2,
    CY_ER_B = 3'd3,
    CY_STAT = 3'd4
  } cyc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WEN, S_GAP, S_OP, S_ADR, S_DAT, S_PCMD, S_PRD
  } st_e;

  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_RD   = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_ERS  = 8'h20;
  localparam logic [7:0] OP_ERB  = 8'hD8;
  localparam logic [7:0] OP_STAT = 8'h05;

  localparam int B_DONE = 0;
  localparam int B_ERR  = 1;
  localparam int B_BUSY = 2;
  localparam int B_GO   = 8;
  localparam int B_TYP  = 9;
  localparam int B_CNT  = 16;

  function automatic logic [7:0] opcode(cyc_e c);
    case (c)
      CY_RD:   return OP_RD;
      CY_PROG: return OP_PROG;
      CY_ER_S: return OP_ERS;
      CY_ER_B: return OP_ERB;
      default: return OP_STAT;
    endcase
  endfunction
endpackage

// File: rtl/spi_hwseq_byte.sv
module spi_hwseq_byte #(
  parameter int DIV = 2,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] txd,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rxd,
  output logic       fin
);
  logic          act;
  logic [CW-1:0] dc;
  logic [2:0]    bc;
  logic [7:0]    sh;

  assign mosi = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0; dc <= '0; bc <= '0; sh <= '0;
      sclk <= 1'b0; rxd <= '0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!act) begin
        if (start) begin
          act <= 1'b1; sh <= txd; dc <= '0; bc <= '0; sclk <= 1'b0;
        end
      end else if (dc == CW'(DIV - 1)) begin
        dc <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rxd  <= {rxd[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bc == 3'd7) begin
            act <= 1'b0;
            fin <= 1'b1;
          end else begin
            bc <= bc + 3'd1;
            sh <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        dc <= dc + CW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_hwseq_buf.sv
module spi_hwseq_buf #(
  parameter int BYTES = 64,
  localparam int WORDS = BYTES / 4,
  localparam int WW = $clog2(WORDS),
  localparam int BW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic [WW-1:0] a_word,
  input  logic          a_we,
  input  logic [3:0]    a_be,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  input  logic [BW-1:0] b_idx,
  input  logic          b_we,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  logic [7:0] lane_q [4];
  logic [1:0] b_lane_q;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (a_we && a_be[l]) mem[a_word] <= a_wdata[8*l +: 8];
      a_rdata[8*l +: 8] <= mem[a_word];
    end
    always_ff @(posedge clk) begin
      if (b_we && b_idx[1:0] == 2'(l)) mem[b_idx[BW-1:2]] <= b_wdata;
      lane_q[l] <= mem[b_idx[BW-1:2]];
    end
  end

  always_ff @(posedge clk) b_lane_q <= b_idx[1:0];
  assign b_rdata = lane_q[b_lane_q];
endmodule

// File: rtl/spi_hwseq.sv
module spi_hwseq
  import spi_hwseq_pkg::*;
#(
  parameter int BUF_BYTES  = 64,
  parameter int CLK_DIV    = 2,
  parameter int POLL_MAX   = 100000,
  parameter int PAGE_BYTES = 256,
  localparam int AW = $clog2(BUF_BYTES) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          spi_sclk,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int BW  = $clog2(BUF_BYTES);
  localparam int GAP = 2 * CLK_DIV;
  localparam int GW  = $clog2(GAP + 1);
  localparam int PCW = $clog2(POLL_MAX + 1);
  localparam int PGW = $clog2(PAGE_BYTES);

  st_e            st, nxt;
  cyc_e           typ;
  logic [7:0]     cnt_m1, left;
  logic [23:0]    faddr, ash;
  logic [1:0]     abyte;
  logic [BW-1:0]  idx;
  logic [GW-1:0]  gcnt;
  logic [PCW-1:0] polls;
  logic           done_f, err_f, cs_n_q, bstart, fin, sel_buf_q;
  logic [7:0]     btx, rxd, b_rdata;
  logic [31:0]    reg_q, buf_rdata;

  wire        is_reg = !bus_addr[AW-1];
  wire [AW-4:0] word = bus_addr[AW-2:2];
  wire        ctl_wr = bus_wr && is_reg && word == '0;
  wire        fa_wr  = bus_wr && is_reg && word == (AW-3)'(1);
  wire        busy   = (st != S_IDLE);
  wire [2:0]  wtyp   = bus_wdata[B_TYP +: 3];
  wire [7:0]  wcnt   = bus_wdata[B_CNT +: 8];
  wire        w_data = (wtyp == CY_RD) || (wtyp == CY_PROG) || (wtyp == CY_STAT);
  wire        bad    = (wtyp > 3'd4) ||
                       (w_data && int'(wcnt) >= BUF_BYTES) ||
                       (wtyp == CY_PROG && int'(faddr[PGW-1:0]) + int'(wcnt) >= PAGE_BYTES);
  wire        needs_wen = (wtyp == CY_PROG) || (wtyp == CY_ER_S) || (wtyp == CY_ER_B);
  wire        b_we   = (st == S_DAT) && fin && (typ != CY_PROG);
  wire [31:0] status = {8'h00, cnt_m1, 4'h0, typ, 1'b0, 5'h00, busy, err_f, done_f};

  spi_hwseq_byte #(.DIV(CLK_DIV)) u_byte (
    .clk(clk), .rst(rst), .start(bstart), .txd(btx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rxd(rxd), .fin(fin)
  );

  spi_hwseq_buf #(.BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .a_word(bus_addr[AW-2:2]), .a_we(bus_wr && !is_reg), .a_be(bus_be),
    .a_wdata(bus_wdata), .a_rdata(buf_rdata),
    .b_idx(idx), .b_we(b_we), .b_wdata(rxd), .b_rdata(b_rdata)
  );

  assign spi_cs_n  = cs_n_q;
  assign bus_rdata = sel_buf_q ? buf_rdata : reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_buf_q <= 1'b0; reg_q <= '0; faddr <= '0;
    end else begin
      if (fa_wr) faddr <= bus_wdata[23:0];
      if (bus_rd) begin
        sel_buf_q <= !is_reg;
        reg_q <= (word == '0) ? status : (word == (AW-3)'(1)) ? {8'h00, faddr} : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; nxt <= S_IDLE; typ <= CY_RD; cnt_m1 <= '0; left <= '0;
      ash <= '0; abyte <= '0; idx <= '0; gcnt <= '0; polls <= '0;
      done_f <= 1'b0; err_f <= 1'b0; cs_n_q <= 1'b1; bstart <= 1'b0; btx <= '0;
    end else begin
      bstart <= 1'b0;
      if (ctl_wr) begin
        if (bus_wdata[B_DONE]) done_f <= 1'b0;
        if (bus_wdata[B_ERR])  err_f  <= 1'b0;
      end
      case (st)
        S_IDLE: if (ctl_wr && bus_wdata[B_GO]) begin
          if (bad) err_f <= 1'b1;
          else begin
            typ <= cyc_e'(wtyp); cnt_m1 <= wcnt; left <= wcnt; idx <= '0;
            ash <= faddr; abyte <= '0; polls <= '0; cs_n_q <= 1'b0; bstart <= 1'b1;
            if (needs_wen) begin btx <= OP_WEN; st <= S_WEN; end
            else begin btx <= opcode(cyc_e'(wtyp)); st <= S_OP; end
          end
        end
        S_WEN: if (fin) begin
          cs_n_q <= 1'b1; gcnt <= '0; nxt <= S_OP; st <= S_GAP;
        end
        S_GAP: if (gcnt == GW'(GAP - 1)) begin
          cs_n_q <= 1'b0; bstart <= 1'b1; st <= nxt;
          btx <= (nxt == S_OP) ? opcode(typ) : OP_STAT;
        end else gcnt <= gcnt + GW'(1);
        S_OP: if (fin) begin
          bstart <= 1'b1;
          if (typ == CY_STAT) begin btx <= 8'h00; st <= S_DAT; end
          else begin btx <= ash[23:16]; ash <= {ash[15:0], 8'h00}; st <= S_ADR; end
        end
        S_ADR: if (fin) begin
          if (abyte == 2'd2) begin
            if (typ == CY_ER_S || typ == CY_ER_B) begin
              cs_n_q <= 1'b1; gcnt <= '0; nxt <= S_PCMD; st <= S_GAP;
            end else begin
              bstart <= 1'b1; st <= S_DAT;
              if (typ == CY_PROG) begin btx <= b_rdata; idx <= idx + BW'(1); end
              else btx <= 8'h00;
            end
          end else begin
            abyte <= abyte + 2'd1; bstart <= 1'b1;
            btx <= ash[23:16]; ash <= {ash[15:0], 8'h00};
          end
        end
        S_DAT: if (fin) begin
          if (typ != CY_PROG) idx <= idx + BW'(1);
          if (left == 8'd0) begin
            cs_n_q <= 1'b1;
            if (typ == CY_PROG) begin gcnt <= '0; nxt <= S_PCMD; st <= S_GAP; end
            else begin done_f <= 1'b1; st <= S_IDLE; end
          end else begin
            left <= left - 8'd1; bstart <= 1'b1;
            if (typ == CY_PROG) begin btx <= b_rdata; idx <= idx + BW'(1); end
            else btx <= 8'h00;
          end
        end
        S_PCMD: if (fin) begin
          bstart <= 1'b1; btx <= 8'h00; st <= S_PRD;
        end
        S_PRD: if (fin) begin
          cs_n_q <= 1'b1;
          if (!rxd[0]) begin done_f <= 1'b1; st <= S_IDLE; end
          else if (polls == PCW'(POLL_MAX - 1)) begin err_f <= 1'b1; st <= S_IDLE; end
          else begin polls <= polls + PCW'(1); gcnt <= '0; nxt <= S_PCMD; st <= S_GAP; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_hwseq_chk.sv
module spi_hwseq_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        sclk,
  input logic        busy,
  input logic        done_f,
  input logic        err_f,
  input logic        ctl_wr,
  input logic [31:0] wdata
);
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);  // R13
  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);  // R12
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(done_f) |-> $past(busy));  // R8
  AST_REJECT_NO_CS: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_f) && !$past(busy)) |-> (cs_n && !busy));  // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wdata[1] && !wdata[8] && !busy) |=> !err_f);  // R11
endmodule

bind spi_hwseq spi_hwseq_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sclk(spi_sclk), .busy(busy),
  .done_f(done_f), .err_f(err_f), .ctl_wr(ctl_wr), .wdata(bus_wdata)
);

// File: tb/sim_spi_hwseq.sv
module sim_spi_hwseq;
  logic clk = 1'b0, rst = 1'b1;
  logic [6:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  always #10 clk = ~clk;

  spi_hwseq #(.BUF_BYTES(64), .CLK_DIV(2), .POLL_MAX(6), .PAGE_BYTES(256)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0, n_fail = 0, idle_clk_err = 0;
  bit finished = 1'b0;

  // behavioural flash model
  logic [7:0] fl_mem [0:4095];
  logic [7:0] insh, outsh = 8'h00, op;
  logic [23:0] fa, fr_a;
  int bitc, bytec, wip_left = 0;
  bit wel = 1'b0, stuck = 1'b0;
  logic [7:0] fr_op[$];
  int fr_len[$];
  logic [23:0] fr_adr[$];

  assign spi_miso = outsh[7];
  function automatic logic [7:0] fstat();
    return {6'b0, wel, (wip_left > 0)};
  endfunction

  always @(negedge spi_cs_n) begin bitc = 0; bytec = 0; outsh = 8'h00; end
  always @(posedge spi_sclk) if (!spi_cs_n) begin insh = {insh[6:0], spi_mosi}; bitc++; end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    if (bitc == 8) begin
      bitc = 0;
      if (bytec == 0) begin
        op = insh;
        if (insh == 8'h06) wel = 1'b1;
        if (insh == 8'h05) outsh = fstat();
      end else if (op == 8'h05) outsh = fstat();
      else if (bytec <= 3) begin
        fa = {fa[15:0], insh};
        if (bytec == 3) begin
          fr_a = fa;
          if (op == 8'h03) begin outsh = fl_mem[fa[11:0]]; fa = fa + 1; end
        end
      end else if (op == 8'h03) begin outsh = fl_mem[fa[11:0]]; fa = fa + 1; end
      else if (op == 8'h02 && wel) begin fl_mem[fa[11:0]] = insh; fa = fa + 1; end
      bytec++;
    end else outsh = {outsh[6:0], 1'b0};
  end
  always @(posedge spi_cs_n) if (!rst) begin
    fr_op.push_back(op); fr_len.push_back(bytec); fr_adr.push_back(fr_a);
    if ((op == 8'h02 || op == 8'h20 || op == 8'hD8) && wel) begin
      wel = 1'b0;
      wip_left = stuck ? 1000000 : 3;
      if (op != 8'h02) for (int i = 0; i < 4096; i++) fl_mem[i] = 8'hFF;
    end
    if (op == 8'h05 && wip_left > 0) wip_left--;
  end

  // per-clock protocol monitor
  always @(negedge clk) if (!rst && spi_cs_n && spi_sclk) idle_clk_err++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic br(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] d);
    for (int i = 0; i < 20000; i++) begin
      br(7'h00, d);
      if (!d[2]) break;
    end
  endtask

  task automatic clear_log();
    fr_op.delete(); fr_len.delete(); fr_adr.delete();
  endtask

  function automatic logic [31:0] go(input int t, input int cm1);
    return 32'h100 | (32'(t) << 9) | (32'(cm1) << 16);
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 4096; i++) fl_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    br(7'h00, d);
    chk(d == 32'h0, "R1 ctrl", d, 32'h0);
    chk(spi_cs_n && !spi_sclk, "R1 pins", {spi_cs_n, spi_sclk}, 32'h2);

    // R2 buffer byte lanes, alignment, address register
    bw(7'h40, 32'h44332211);
    bw(7'h44, 32'h88776655);
    bw(7'h46, 32'h0000BB00, 4'b0010);
    br(7'h47, d);
    chk(d == 32'h8877BB55, "R2 byte lane", d, 32'h8877BB55);
    bw(7'h05, 32'hAB000100);
    br(7'h04, d);
    chk(d == 32'h00000100, "R2 addr reg", d, 32'h100);

    // R5 program 8 bytes at 0x100, R3 fields, R12 busy
    clear_log();
    bw(7'h00, go(1, 7));
    br(7'h00, d);
    chk(d[2] == 1'b1, "R12 busy bit", d, 32'h4);
    chk(d[23:16] == 8'd7 && d[11:9] == 3'd1, "R3 fields", d, 32'h00070200);
    wait_idle(d);
    chk(d[1:0] == 2'b01, "R5 done", d, 32'h1);
    chk(fr_op.size() == 6 && fr_op[0] == 8'h06 && fr_len[0] == 1 &&
        fr_op[1] == 8'h02 && fr_len[1] == 12 && fr_adr[1] == 24'h100,
        "R5 frames", {fr_op[0], fr_op[1], 8'(fr_len[1]), 8'(fr_op.size())}, 32'h06020C06);
    chk({fl_mem[12'h103], fl_mem[12'h102], fl_mem[12'h101], fl_mem[12'h100]} == 32'h44332211 &&
        {fl_mem[12'h107], fl_mem[12'h106], fl_mem[12'h105], fl_mem[12'h104]} == 32'h8877BB55,
        "R5 data", {fl_mem[12'h103], fl_mem[12'h102], fl_mem[12'h101], fl_mem[12'h100]}, 32'h44332211);
    chk(fr_op[5] == 8'h05 && fr_len[5] == 2 && fr_op[2] == 8'h05, "R8 poll frames",
        {fr_op[5], 8'(fr_len[5])}, 32'h0502);

    // R11 clear done
    bw(7'h00, 32'h1);
    br(7'h00, d);
    chk(d[0] == 1'b0, "R11 clear done", d, 32'h0);

    // R4 read back 8 bytes
    bw(7'h40, 32'h0); bw(7'h44, 32'h0);
    clear_log();
    bw(7'h00, go(0, 7));
    wait_idle(d);
    chk(fr_op.size() == 1 && fr_op[0] == 8'h03 && fr_len[0] == 12 && fr_adr[0] == 24'h100,
        "R4 frame", {fr_op[0], 8'(fr_len[0])}, 32'h030C);
    br(7'h40, d);
    chk(d == 32'h44332211, "R4 word0", d, 32'h44332211);
    br(7'h44, d);
    chk(d == 32'h8877BB55, "R4 word1", d, 32'h8877BB55);
    bw(7'h00, 32'h0);
    br(7'h00, d);
    chk(d[0] == 1'b1, "R11 zero keeps done", d, 32'h1);
    bw(7'h00, 32'h3);

    // R7 read status
    bw(7'h40, 32'hFFFFFFFF);
    clear_log();
    bw(7'h00, go(4, 0));
    wait_idle(d);
    br(7'h40, d);
    chk(d == 32'hFFFFFF00 && fr_op[0] == 8'h05 && fr_len[0] == 2, "R7 status", d, 32'hFFFFFF00);
    bw(7'h00, 32'h3);

    // R6 sector and block erase
    bw(7'h04, 32'h000000);
    clear_log();
    bw(7'h00, go(2, 0));
    wait_idle(d);
    chk(d[1:0] == 2'b01 && fr_op[0] == 8'h06 && fr_op[1] == 8'h20 && fr_len[1] == 4,
        "R6 sector erase", {fr_op[1], 8'(fr_len[1])}, 32'h2004);
    chk(fl_mem[12'h100] == 8'hFF, "R6 erased", fl_mem[12'h100], 32'hFF);
    bw(7'h00, 32'h3);
    clear_log();
    bw(7'h00, go(3, 0));
    wait_idle(d);
    chk(d[1:0] == 2'b01 && fr_op[1] == 8'hD8 && fr_len[1] == 4,
        "R6 block erase", {fr_op[1], 8'(fr_len[1])}, 32'hD804);
    bw(7'h00, 32'h3);

    // R10 rejected requests
    clear_log();
    bw(7'h00, go(0, 64));
    br(7'h00, d);
    chk(d[2:0] == 3'b010 && fr_op.size() == 0, "R10 count too big", d, 32'h2);
    bw(7'h00, 32'h2);
    bw(7'h04, 32'h0000F8);
    bw(7'h00, go(1, 15));
    br(7'h00, d);
    chk(d[2:0] == 3'b010 && fr_op.size() == 0, "R10 page cross", d, 32'h2);
    bw(7'h00, 32'h2);
    bw(7'h00, go(5, 0));
    br(7'h00, d);
    chk(d[2:0] == 3'b010 && fr_op.size() == 0, "R10 bad type", d, 32'h2);
    bw(7'h00, 32'h2);
    // boundary: exactly fills the page
    bw(7'h40, 32'hCAFEF00D); bw(7'h44, 32'h12345678);
    bw(7'h00, go(1, 7));
    wait_idle(d);
    chk(d[1:0] == 2'b01 && fl_mem[12'h0F8] == 8'h0D && fl_mem[12'h0FF] == 8'h12,
        "R10 page edge ok", {fl_mem[12'h0F8], fl_mem[12'h0FF]}, 32'h0D12);
    bw(7'h00, 32'h3);

    // R12 go during busy ignored
    bw(7'h04, 32'h000100);
    clear_log();
    bw(7'h00, go(0, 63));
    bw(7'h00, go(2, 0));
    wait_idle(d);
    chk(d[1:0] == 2'b01 && fr_op.size() == 1 && fr_op[0] == 8'h03 && fr_len[0] == 68,
        "R12 second go ignored", {8'(fr_op.size()), 8'(fr_len[0])}, 32'h0144);
    bw(7'h00, 32'h3);

    // R9 poll timeout
    stuck = 1'b1;
    clear_log();
    bw(7'h00, go(2, 0));
    wait_idle(d);
    chk(d[1:0] == 2'b10 && fr_op.size() == 8, "R9 timeout", {d[7:0], 8'(fr_op.size())}, 32'h0208);
    stuck = 1'b0; wip_left = 0;
    bw(7'h00, 32'h3);

    chk(idle_clk_err == 0, "R13 sclk low with cs high", idle_clk_err, 0);
    report();
  end
endmodule